// File: doc/BRIEF.md
# Leaky Failure-Event Integrator for Clock Reference Qualification

This block decides whether a clock reference is fit for use. It does not react to a single short fault. It integrates fault indications over time in a saturating counter that leaks, in the way an analog integrator with a bleed resistor would. Two fault inputs feed it: a coarse frequency monitor and a cycle-count monitor. A shared prescaled sample tick paces the block. On each tick with a fault present, the level rises by one. When the reference is quiet, the level drains by one only every 2^k ticks, where k is a software-chosen rate.

A guard fail flag rises when the level reaches a programmable upper threshold. It then stays raised until the level has drained down to a programmable lower threshold. Starting empty, disqualification takes `hi` fault ticks. Starting from saturation, requalification takes `(hi - lo) * 2^k` quiet ticks. The quiet time is therefore a power-of-two multiple of the fault time, chosen by the decay select.

The thresholds are meant to satisfy `lo < hi`.

Top module: `ref_soak_guard`

## Requirements
- R1: On a sample tick where either fault input is high, the level rises by exactly one. With both inputs high, the level still rises by only one.
- R2: Sample ticks occur once every TICK_DIV clock cycles. The level changes only on a tick.
- R3: The flag is set on the same clock edge at which the level reaches `hi`. From an empty level under a constant fault, the flag rises after exactly `hi` ticks.
- R4: Once set, the flag stays high while the level lies above `lo`, including while the level is draining.
- R5: On quiet ticks, the level falls by one on every 2^k-th consecutive quiet tick. k is `decay_sel_i`: code 0 gives every tick, 1 every 2nd, 2 every 4th and 3 every 8th.
- R6: A fault tick restarts the count of quiet ticks. From a saturated level, the flag clears exactly `(hi - lo) * 2^k` quiet ticks after the last fault tick.
- R7: The level saturates at `hi`. Extra fault ticks beyond saturation do not lengthen the later qualification time.
- R8: The level floors at zero and never wraps. After any length of quiet time, exactly `hi` fault ticks are needed to set the flag.
- R9: While `rst_ni` is low, the level is zero and the flag is low. Release takes effect two clock edges after `rst_ni` rises. The first tick follows TICK_DIV cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freq_fail_i | input | 1 | Fault indication from the coarse frequency monitor |
| cnt_fail_i | input | 1 | Fault indication from the cycle-count monitor |
| hi_thresh_i | input | ACC_W | Level at which the flag is set (disqualify) |
| lo_thresh_i | input | ACC_W | Level at or below which the flag clears (requalify) |
| decay_sel_i | input | 2 | Leak rate k: one decrement per 2^k quiet ticks |
| guard_fail_o | output | 1 | Guard fail flag, high while the reference is disqualified |

## Verification
The bound checker watches the following on every clock:
- the level moves only on ticks;
- a fault tick adds exactly one below `hi` and clamps to `hi` at or above it;
- a leak at zero leaves the level at zero, and any other leak removes exactly one;
- reaching `hi` raises the flag;
- the flag cannot fall without a leak while the level is above `lo`.

Some properties are statements about long stretches of time and can only be shown by the bench's scenarios:
- the exact disqualification and qualification durations for each decay code;
- the restart of the quiet count by a lone fault tick;
- the equal treatment of the two fault sources;
- the tick phase after reset release.

// File: rtl/soak_pkg.sv
package soak_pkg;

  localparam int RATE_W = 2;
  localparam int LIM_W  = (2 ** RATE_W) - 1;

  typedef enum logic [RATE_W-1:0] {
    LEAK_EVERY_1 = 2'd0,
    LEAK_EVERY_2 = 2'd1,
    LEAK_EVERY_4 = 2'd2,
    LEAK_EVERY_8 = 2'd3
  } leak_rate_e;

  // Last value of the quiet-tick counter before a decrement is due.
  function automatic logic [LIM_W-1:0] leak_limit(input leak_rate_e rate);
    logic [LIM_W:0] one_hot;
    one_hot = '0;
    one_hot[rate] = 1'b1;
    return LIM_W'(one_hot - 1'b1);
  endfunction

endpackage

// File: rtl/soak_rst_sync.sv
module soak_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/soak_tick_gen.sv
module soak_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = wrap;

endmodule

// File: rtl/soak_leak_div.sv
module soak_leak_div
  import soak_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fail_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              leak_o
);

  logic [LIM_W-1:0] quiet_q;
  logic [LIM_W-1:0] quiet_d;
  logic [LIM_W-1:0] limit;
  logic             quiet_en;
  logic             due;

  always_comb begin
    limit    = leak_limit(leak_rate_e'(rate_i));
    due      = (quiet_q == limit);
    quiet_en = tick_i;
    quiet_d  = quiet_q;
    if (fail_i) begin
      quiet_d = '0;
    end else if (due) begin
      quiet_d = '0;
    end else begin
      quiet_d = quiet_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= '0;
    end else if (quiet_en) begin
      quiet_q <= quiet_d;
    end
  end

  assign leak_o = tick_i & ~fail_i & due;

endmodule

// File: rtl/soak_accum.sv
module soak_accum #(
  parameter int ACC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fail_i,
  input  logic             leak_i,
  input  logic [ACC_W-1:0] hi_i,
  input  logic [ACC_W-1:0] lo_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             flag_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             flag_q;
  logic             flag_d;
  logic             acc_en;

  always_comb begin
    acc_en = tick_i & (fail_i | leak_i);
    acc_d  = acc_q;
    if (tick_i && fail_i) begin
      acc_d = (acc_q >= hi_i) ? hi_i : acc_q + 1'b1;
    end else if (leak_i) begin
      acc_d = (acc_q == '0) ? '0 : acc_q - 1'b1;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (acc_d >= hi_i) begin
      flag_d = 1'b1;
    end else if (acc_d <= lo_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign acc_o  = acc_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/ref_soak_guard.sv
module ref_soak_guard
  import soak_pkg::*;
#(
  parameter int ACC_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freq_fail_i,
  input  logic              cnt_fail_i,
  input  logic [ACC_W-1:0]  hi_thresh_i,
  input  logic [ACC_W-1:0]  lo_thresh_i,
  input  logic [RATE_W-1:0] decay_sel_i,
  output logic              guard_fail_o
);

  logic             rst_sync_n;
  logic             tick;
  logic             fail_any;
  logic             leak;
  logic [ACC_W-1:0] acc_q;

  assign fail_any = freq_fail_i | cnt_fail_i;

  soak_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  soak_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_o (tick)
  );

  soak_leak_div u_leak (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_i (tick),
    .fail_i (fail_any),
    .rate_i (decay_sel_i),
    .leak_o (leak)
  );

  soak_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_i (tick),
    .fail_i (fail_any),
    .leak_i (leak),
    .hi_i   (hi_thresh_i),
    .lo_i   (lo_thresh_i),
    .acc_o  (acc_q),
    .flag_o (guard_fail_o)
  );

endmodule

// File: rtl/ref_soak_guard_chk.sv
module ref_soak_guard_chk #(
  parameter int ACC_W = 8
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             tick_i,
  input logic             fail_i,
  input logic             leak_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [ACC_W-1:0] hi_i,
  input logic [ACC_W-1:0] lo_i,
  input logic             flag_i
);

  // R2: level is frozen between ticks
  a_r2_hold_off_tick: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !tick_i |=> $stable(acc_i));

  // R1: a fault tick below the upper threshold adds exactly one
  a_r1_step_up: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tick_i && fail_i && (acc_i < hi_i)) |=> (acc_i == $past(acc_i) + 1'b1));

  // R7: a fault tick at or above the upper threshold clamps the level
  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tick_i && fail_i && (acc_i >= hi_i)) |=> (acc_i == $past(hi_i)));

  // R8: a leak at zero leaves the level at zero
  a_r8_floor: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (leak_i && (acc_i == '0)) |=> (acc_i == '0));

  // R5: a leak above zero removes exactly one
  a_r5_leak_step: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (leak_i && (acc_i != '0)) |=> (acc_i == $past(acc_i) - 1'b1));

  // R5: a quiet tick that is not due for a leak keeps the level
  a_r5_quiet_keep: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tick_i && !fail_i && !leak_i) |=> $stable(acc_i));

  // R3: reaching the upper threshold raises the flag
  a_r3_set: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tick_i && fail_i && (({1'b0, acc_i} + 1'b1) >= {1'b0, hi_i})) |=> flag_i);

  // R4: without a leak the flag cannot fall while the level is above lo
  a_r4_hysteresis: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (flag_i && !leak_i && (acc_i > lo_i)) |=> flag_i);

endmodule

bind ref_soak_guard ref_soak_guard_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_n_i (rst_sync_n),
  .tick_i  (tick),
  .fail_i  (fail_any),
  .leak_i  (leak),
  .acc_i   (acc_q),
  .hi_i    (hi_thresh_i),
  .lo_i    (lo_thresh_i),
  .flag_i  (guard_fail_o)
);

// File: tb/tb_ref_soak_guard.sv
module tb_ref_soak_guard;

  localparam int ACC_W    = 8;
  localparam int TICK_DIV = 4;

  logic             clk;
  logic             rst_n;
  logic             ff;
  logic             cf;
  logic [ACC_W-1:0] hi;
  logic [ACC_W-1:0] lo;
  logic [1:0]       sel;
  logic             flag;

  int    n_cmp;
  int    n_bad;
  bit    cmp_en;
  bit    done;
  string tag;

  ref_soak_guard #(.ACC_W(ACC_W), .TICK_DIV(TICK_DIV)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .freq_fail_i  (ff),
    .cnt_fail_i   (cf),
    .hi_thresh_i  (hi),
    .lo_thresh_i  (lo),
    .decay_sel_i  (sel),
    .guard_fail_o (flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Requirement model
  logic [1:0]       m_sync;
  int               m_pcnt;
  logic [2:0]       m_dcnt;
  logic [ACC_W-1:0] m_acc;
  logic             m_flag;
  int               m_ticks;

  bit               v_tk;
  bit               v_fl;
  logic [2:0]       v_lim;
  logic [2:0]       v_dc;
  logic [ACC_W-1:0] v_a;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync  <= 2'b00;
      m_pcnt  <= 0;
      m_dcnt  <= 3'd0;
      m_acc   <= '0;
      m_flag  <= 1'b0;
      m_ticks <= 0;
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (m_sync[1]) begin
        v_tk  = (m_pcnt == TICK_DIV - 1);
        v_fl  = ff | cf;
        v_lim = 3'((1 << sel) - 1);
        v_a   = m_acc;
        v_dc  = m_dcnt;
        if (v_tk) begin
          if (v_fl) begin
            v_dc = 3'd0;
            v_a  = (m_acc >= hi) ? hi : m_acc + 1'b1;
          end else if (m_dcnt == v_lim) begin
            v_dc = 3'd0;
            v_a  = (m_acc == '0) ? '0 : m_acc - 1'b1;
          end else begin
            v_dc = m_dcnt + 3'd1;
          end
          m_ticks <= m_ticks + 1;
        end
        m_pcnt <= v_tk ? 0 : m_pcnt + 1;
        m_acc  <= v_a;
        m_dcnt <= v_dc;
        if (v_a >= hi)      m_flag <= 1'b1;
        else if (v_a <= lo) m_flag <= 1'b0;
      end
    end
  end

  function automatic bit same(input logic a, input logic b);
    return a === b;
  endfunction

  task automatic check_int(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      n_cmp++;
      if (!same(flag, m_flag)) begin
        n_bad++;
        $display("FAIL %s: flag actual %b expected %b at %0t", tag, flag, m_flag, $time);
      end
    end
  end

  task automatic wait_ticks(input int n);
    int t0;
    t0 = m_ticks;
    while (m_ticks - t0 < n) @(negedge clk);
  endtask

  task automatic measure(input string req, input logic lvl, input int exp);
    int t0;
    int guard;
    t0 = m_ticks;
    guard = 0;
    while (flag !== lvl && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    check_int(req, m_ticks - t0, exp);
  endtask

  task automatic drain();
    ff = 1'b0;
    cf = 1'b0;
    wait_ticks(int'(hi) * 8 + 8);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_cmp = 0; n_bad = 0; cmp_en = 1'b0; done = 1'b0; tag = "R9";
    rst_n = 1'b0; ff = 1'b0; cf = 1'b0;
    hi = 8'd6; lo = 8'd2; sel = 2'd0;
    repeat (3) @(negedge clk);
    check_int("R9 reset flag", int'(flag), 0);
    ff = 1'b1;
    @(negedge clk);
    check_int("R9 flag held in reset under fault", int'(flag), 0);
    ff = 1'b0;
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (2) @(negedge clk);
    check_int("R9 flag after release", int'(flag), 0);

    // R1 R3: coarse frequency fault alone, from empty
    tag = "R3";
    ff = 1'b1;
    measure("R1 R3 set by freq fault", 1'b1, 6);
    // R7: hold fault well past saturation
    tag = "R7";
    wait_ticks(10);
    ff = 1'b0;
    measure("R7 R6 clear after saturation k0", 1'b0, 4);

    // R8 R5 k=2: drain to floor, cycle monitor alone
    tag = "R8";
    sel = 2'd2;
    drain();
    cf = 1'b1;
    measure("R8 R1 set by cycle fault", 1'b1, 6);
    cf = 1'b0;
    measure("R5 R6 clear k2", 1'b0, 16);

    // R1 both sources at once count one per tick
    tag = "R1";
    hi = 8'd9; lo = 8'd4; sel = 2'd1;
    drain();
    ff = 1'b1; cf = 1'b1;
    measure("R1 both sources", 1'b1, 9);
    ff = 1'b0; cf = 1'b0;
    measure("R6 clear k1", 1'b0, 10);

    // R4 hysteresis mid-drain
    tag = "R4";
    hi = 8'd10; lo = 8'd3; sel = 2'd1;
    drain();
    ff = 1'b1;
    wait_ticks(13);
    ff = 1'b0;
    wait_ticks(6);
    check_int("R4 flag held while draining", int'(flag), 1);
    measure("R4 remaining drain", 1'b0, 8);

    // R6 lone fault tick restarts quiet count, k=3
    tag = "R6";
    hi = 8'd5; lo = 8'd1; sel = 2'd3;
    drain();
    cf = 1'b1;
    wait_ticks(8);
    cf = 1'b0;
    wait_ticks(5);
    cf = 1'b1;
    wait_ticks(1);
    cf = 1'b0;
    check_int("R6 flag still set", int'(flag), 1);
    measure("R6 restart clear k3", 1'b0, 32);

    // R8 after long quiet exactly hi fault ticks are needed
    tag = "R8";
    hi = 8'd7; lo = 8'd2; sel = 2'd0;
    drain();
    wait_ticks(40);
    ff = 1'b1;
    measure("R8 set from floor", 1'b1, 7);
    ff = 1'b0;

    // Random stimulus, per-cycle model compare
    tag = "R2 R5 random";
    begin
      int seed;
      int pct;
      seed = 17;
      void'($urandom(seed));
      pct = 50;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 400) == 0) begin
          hi  = 8'(3 + ($urandom % 18));
          lo  = 8'($urandom % hi);
          sel = 2'($urandom % 4);
          pct = 10 + ($urandom % 70);
        end
        ff = (($urandom % 100) < pct / 2);
        cf = (($urandom % 100) < pct / 2);
        @(negedge clk);
      end
    end
    ff = 1'b0; cf = 1'b0;
    repeat (4) @(negedge clk);
    cmp_en = 1'b0;
    summary();
  end

endmodule